// File: doc/BRIEF.md
# Station Address Table Loader

This block gives a host controlled write access to the two station address tables of a network receiver: a 6-byte physical station address and an 8-byte multicast logical address filter. The host first writes a configuration byte. One bit of it asks for access and one of two select bits picks the table. The host then streams bytes through a single data port. Each accepted byte goes to the next location of the selected table.

Access is granted through a request bit that clears itself. If the receiver has not been enabled since the last hardware or software reset, the request clears at once. Otherwise it stays set until the receiver reports that it is between frames, or until the receiver is disabled. Both tables are presented in full on parallel outputs for the match logic, along with a flag that shows when the selected table is fully loaded.

Top module: `addr_ram_loader`

## Requirements
- R1: After reset, `cfg_rdata`, `phys_addr`, `log_filter` and `load_done` are all zero. No table is selected and the receiver counts as never enabled.
- R2: If the receiver has not been enabled since the last reset, a configuration write with bit 7 (access request) set leaves `cfg_rdata[7]` at 0 in the next cycle.
- R3: Once the receiver has been enabled, a request sets `cfg_rdata[7]` to 1 from the next cycle. The bit clears at the first clock edge that sees `rcv_idle` high or `rcv_en` low.
- R4: Configuration byte encoding: bit 7 requests access, bit 2 selects the physical address, bit 1 selects the logical filter. `cfg_rdata` returns the request state on bit 7 and the current selection on bits 2 and 1, with all other bits zero. A write with neither select bit set keeps the selection and the byte position.
- R5: The k-th byte accepted after a selection is stored in bits [8k+7:8k] of the selected table. The physical address has 6 bytes and the logical filter has 8.
- R6: Writing a select bit resets the byte position to 0, so a reload starts again at the lowest byte and leaves the higher bytes unchanged until they are overwritten.
- R7: `load_done` is high when a table is selected and all of its bytes have been written. Further data writes to that table are ignored.
- R8: Data writes made while `cfg_rdata[7]` is 1 are ignored.
- R9: When both select bits are written together, the physical address is selected.
- R10: If a configuration write and a data write fall in the same cycle, the data byte is discarded and the configuration write takes effect.
- R11: `soft_rst` clears both tables, the selection, the byte position and any pending request, and marks the receiver as never enabled.
- R12: Data writes made while no table is selected are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous software reset |
| rcv_en | input | 1 | Receiver enable |
| rcv_idle | input | 1 | Receiver is between frames |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Configuration register readback |
| data_wr | input | 1 | Table data write strobe |
| data_in | input | 8 | Table data byte |
| phys_addr | output | 48 | Physical station address |
| log_filter | output | 64 | Logical address filter |
| load_done | output | 1 | Selected table is fully loaded |

## Verification
Two functions can fall in the same cycle: a configuration write, which reselects a table and resets the byte position, and a data write, which would store a byte and advance that position. The bench drives both strobes in one cycle. It then checks that no table byte changed and that the next lone data byte lands at position 0 of the newly selected table. A second overlap pairs a pending request with data writes, and those writes must leave both tables unchanged until the idle input grants access. The bench also sweeps every reload length of the logical filter from 1 to 8 bytes against an arithmetic model.

// File: rtl/addr_ram_pkg.sv
package addr_ram_pkg;
    localparam int DEF_PHY_BYTES = 6;
    localparam int DEF_LOG_BYTES = 8;
    localparam int CFG_REQ_BIT   = 7;
    localparam int CFG_PHY_BIT   = 2;
    localparam int CFG_LOG_BIT   = 1;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_PHY  = 2'd1,
        TGT_LOG  = 2'd2
    } tgt_e;

    typedef struct packed {
        logic armed;
        logic pend;
    } grant_st_t;
endpackage

// File: rtl/grant_ctrl.sv
module grant_ctrl
    import addr_ram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic rcv_en,
    input  logic rcv_idle,
    input  logic req,
    output logic armed,
    output logic pending
);
    grant_st_t st_d, st_q;
    logic armed_now;

    always_comb begin
        st_d      = st_q;
        armed_now = st_q.armed | rcv_en;
        st_d.armed = armed_now;
        if (req && armed_now) begin
            st_d.pend = 1'b1;
        end else if (st_q.pend && (rcv_idle || !rcv_en)) begin
            st_d.pend = 1'b0;
        end
        if (soft_rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign armed   = st_q.armed;
    assign pending = st_q.pend;
endmodule

// File: rtl/byte_table.sv
module byte_table #(
    parameter int NBYTES = 6,
    parameter int IDX_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                we,
    input  logic [IDX_W-1:0]    idx,
    input  logic [7:0]          din,
    output logic [8*NBYTES-1:0] flat
);
    logic [NBYTES-1:0][7:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            for (int i = 0; i < NBYTES; i++) begin
                if (idx == IDX_W'(i)) mem_d[i] = din;
            end
        end
        if (clr) mem_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign flat = mem_q;
endmodule

// File: rtl/addr_ram_loader.sv
module addr_ram_loader
    import addr_ram_pkg::*;
#(
    parameter int PHY_BYTES = DEF_PHY_BYTES,
    parameter int LOG_BYTES = DEF_LOG_BYTES
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   soft_rst,
    input  logic                   rcv_en,
    input  logic                   rcv_idle,
    input  logic                   cfg_wr,
    input  logic [7:0]             cfg_wdata,
    output logic [7:0]             cfg_rdata,
    input  logic                   data_wr,
    input  logic [7:0]             data_in,
    output logic [8*PHY_BYTES-1:0] phys_addr,
    output logic [8*LOG_BYTES-1:0] log_filter,
    output logic                   load_done
);
    localparam int MAX_BYTES = (PHY_BYTES > LOG_BYTES) ? PHY_BYTES : LOG_BYTES;
    localparam int PTR_W     = $clog2(MAX_BYTES + 1);

    typedef struct packed {
        tgt_e             tgt;
        logic [PTR_W-1:0] ptr;
    } ld_st_t;

    ld_st_t           ld_d, ld_q;
    logic             armed, pending;
    logic             req, sel_phy, sel_log;
    logic [PTR_W-1:0] tlen;
    logic             room, accept, we_phy, we_log;
    logic             cfg_unused;

    assign req        = cfg_wr && cfg_wdata[CFG_REQ_BIT];
    assign sel_phy    = cfg_wdata[CFG_PHY_BIT];
    assign sel_log    = cfg_wdata[CFG_LOG_BIT];
    assign cfg_unused = ^{cfg_wdata[6:3], cfg_wdata[0]};

    grant_ctrl u_grant (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .rcv_en   (rcv_en),
        .rcv_idle (rcv_idle),
        .req      (req),
        .armed    (armed),
        .pending  (pending)
    );

    always_comb begin
        ld_d   = ld_q;
        tlen   = (ld_q.tgt == TGT_PHY) ? PTR_W'(PHY_BYTES) : PTR_W'(LOG_BYTES);
        room   = (ld_q.tgt != TGT_NONE) && (ld_q.ptr < tlen);
        accept = data_wr && !cfg_wr && !soft_rst && !pending && room;
        we_phy = accept && (ld_q.tgt == TGT_PHY);
        we_log = accept && (ld_q.tgt == TGT_LOG);
        if (cfg_wr) begin
            if (sel_phy) begin
                ld_d.tgt = TGT_PHY;
                ld_d.ptr = '0;
            end else if (sel_log) begin
                ld_d.tgt = TGT_LOG;
                ld_d.ptr = '0;
            end
        end else if (accept) begin
            ld_d.ptr = ld_q.ptr + 1'b1;
        end
        if (soft_rst) begin
            ld_d.tgt = TGT_NONE;
            ld_d.ptr = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_q.tgt <= TGT_NONE;
            ld_q.ptr <= '0;
        end else begin
            ld_q <= ld_d;
        end
    end

    byte_table #(.NBYTES(PHY_BYTES), .IDX_W(PTR_W)) u_phy (
        .clk (clk), .rst_n (rst_n), .clr (soft_rst), .we (we_phy),
        .idx (ld_q.ptr), .din (data_in), .flat (phys_addr)
    );

    byte_table #(.NBYTES(LOG_BYTES), .IDX_W(PTR_W)) u_log (
        .clk (clk), .rst_n (rst_n), .clr (soft_rst), .we (we_log),
        .idx (ld_q.ptr), .din (data_in), .flat (log_filter)
    );

    assign cfg_rdata = {pending, 4'b0000, ld_q.tgt == TGT_PHY, ld_q.tgt == TGT_LOG, 1'b0};
    assign load_done = (ld_q.tgt != TGT_NONE) && (ld_q.ptr == tlen);
endmodule

// File: rtl/addr_ram_chk.sv
module addr_ram_chk #(
    parameter int PHY_BYTES = 6,
    parameter int LOG_BYTES = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   soft_rst,
    input logic                   rcv_en,
    input logic                   rcv_idle,
    input logic                   cfg_wr,
    input logic [7:0]             cfg_wdata,
    input logic [7:0]             cfg_rdata,
    input logic                   data_wr,
    input logic                   armed,
    input logic [8*PHY_BYTES-1:0] phys_addr,
    input logic [8*LOG_BYTES-1:0] log_filter,
    input logic                   load_done
);
    assert_unarmed_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[7] && !armed && !rcv_en) |=> !cfg_rdata[7]);

    assert_grant_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[7] && (rcv_idle || !rcv_en) && !cfg_wr) |=> !cfg_rdata[7]);

    assert_pending_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[7] && data_wr && !soft_rst) |=> ($stable(phys_addr) && $stable(log_filter)));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_done && data_wr && !cfg_wr && !soft_rst) |=> ($stable(phys_addr) && $stable(log_filter)));

    assert_phys_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[2] && cfg_wdata[1] && !soft_rst) |=> (cfg_rdata[2] && !cfg_rdata[1]));

    assert_soft_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (phys_addr == '0 && log_filter == '0 && cfg_rdata == 8'h00 && !load_done));

    assert_select_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cfg_rdata[2:1]));
endmodule

bind addr_ram_loader addr_ram_chk #(.PHY_BYTES(PHY_BYTES), .LOG_BYTES(LOG_BYTES)) u_chk (.*);

// File: tb/sim_addr_ram_loader.sv
`timescale 1ns/1ps
module sim_addr_ram_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0, rcv_en = 1'b0, rcv_idle = 1'b0;
    logic        cfg_wr = 1'b0, data_wr = 1'b0;
    logic [7:0]  cfg_wdata = '0, data_in = '0;
    logic [7:0]  cfg_rdata;
    logic [47:0] phys_addr;
    logic [63:0] log_filter;
    logic        load_done;

    int checks = 0, failures = 0;
    bit finished = 0;

    logic [7:0] m_phy [6];
    logic [7:0] m_log [8];
    int  m_tgt = 0, m_ptr = 0;
    bit  m_pend = 0, m_armed = 0;

    always #5 clk = ~clk;

    addr_ram_loader u0 (.*);

    function automatic int tlen();
        return (m_tgt == 1) ? 6 : 8;
    endfunction

    task automatic check_all(string req);
        logic [47:0] ep; logic [63:0] el; logic [7:0] er; logic ed;
        for (int i = 0; i < 6; i++) ep[8*i +: 8] = m_phy[i];
        for (int i = 0; i < 8; i++) el[8*i +: 8] = m_log[i];
        er = {m_pend, 4'b0, m_tgt == 1, m_tgt == 2, 1'b0};
        ed = (m_tgt != 0) && (m_ptr == tlen());
        checks++;
        if (cfg_rdata !== er || phys_addr !== ep || log_filter !== el || load_done !== ed) begin
            failures++;
            $display("FAIL %s: actual cfg=%h phy=%h log=%h done=%b expected cfg=%h phy=%h log=%h done=%b",
                     req, cfg_rdata, phys_addr, log_filter, load_done, er, ep, el, ed);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 6; i++) m_phy[i] = 8'h00;
        for (int i = 0; i < 8; i++) m_log[i] = 8'h00;
        m_tgt = 0; m_ptr = 0; m_pend = 0; m_armed = 0;
    endtask

    // one clock cycle with optional strobes; inputs change at negedge
    task automatic cyc(bit cw, logic [7:0] cb, bit dw, logic [7:0] db, string req);
        bit armed_now;
        cfg_wr = cw; cfg_wdata = cb; data_wr = dw; data_in = db;
        armed_now = m_armed | rcv_en;
        if (cw) begin
            if (cb[2]) begin m_tgt = 1; m_ptr = 0; end
            else if (cb[1]) begin m_tgt = 2; m_ptr = 0; end
        end else if (dw && !m_pend && m_tgt != 0 && m_ptr < tlen()) begin
            if (m_tgt == 1) m_phy[m_ptr] = db; else m_log[m_ptr] = db;
            m_ptr++;
        end
        if (cw && cb[7] && armed_now) m_pend = 1;
        else if (m_pend && (rcv_idle || !rcv_en)) m_pend = 0;
        m_armed = armed_now;
        @(negedge clk);
        cfg_wr = 0; data_wr = 0;
        check_all(req);
    endtask

    task automatic do_soft();
        soft_rst = 1;
        @(negedge clk);
        soft_rst = 0;
        model_clear();
        check_all("R11");
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            failures++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_all("R1");

        // R12: no table selected
        cyc(0, 8'h00, 1, 8'hAA, "R12");
        cyc(0, 8'h00, 1, 8'h55, "R12");

        // R2 / R4: unarmed request with physical select
        cyc(1, 8'h84, 0, 8'h00, "R2");

        // R5: physical address load, then R7 overflow
        for (int i = 0; i < 6; i++) cyc(0, 8'h00, 1, 8'(i * 29 + 11), "R5");
        for (int i = 0; i < 2; i++) cyc(0, 8'h00, 1, 8'hEE, "R7");

        // R4: neither select keeps selection and position
        cyc(1, 8'h00, 0, 8'h00, "R4");

        // R6 / R5: sweep every reload length of the filter
        for (int n = 1; n <= 8; n++) begin
            cyc(1, 8'h02, 0, 8'h00, "R6");
            for (int i = 0; i < n; i++) cyc(0, 8'h00, 1, 8'(n * 16 + i * 7 + 3), "R5");
        end
        for (int i = 0; i < 3; i++) cyc(0, 8'h00, 1, 8'hC3, "R7");

        // R9: both selects
        cyc(1, 8'h06, 0, 8'h00, "R9");
        cyc(0, 8'h00, 1, 8'h9D, "R9");

        // R3 / R8: armed request waits for idle
        rcv_en = 1; rcv_idle = 0;
        cyc(0, 8'h00, 0, 8'h00, "R3");
        cyc(1, 8'h82, 0, 8'h00, "R3");
        for (int i = 0; i < 3; i++) cyc(0, 8'h00, 1, 8'h77, "R8");
        rcv_idle = 1;
        cyc(0, 8'h00, 0, 8'h00, "R3");
        cyc(0, 8'h00, 1, 8'h42, "R3");

        // R10: config and data in the same cycle
        cyc(1, 8'h04, 1, 8'h66, "R10");
        cyc(0, 8'h00, 1, 8'h13, "R10");

        // R3: grant by disabling the receiver
        rcv_idle = 0;
        cyc(1, 8'h80, 0, 8'h00, "R3");
        cyc(0, 8'h00, 0, 8'h00, "R3");
        rcv_en = 0;
        cyc(0, 8'h00, 0, 8'h00, "R3");

        // R11: soft reset disarms, request clears at once
        do_soft();
        cyc(1, 8'h82, 0, 8'h00, "R11");
        cyc(0, 8'h00, 1, 8'h21, "R11");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule